// File: doc/BRIEF.md
# SPI clock and chip-select timing generator

This block derives the serial clock and four active-low device selects of a serial-flash controller from a faster reference clock. A transfer sequencer holds `xfer_req_i` high for as long as it wants the serial clock to run. The block then asserts the chosen select, waits a programmable setup gap, and produces whole serial-clock periods. When the request is seen low at the end of a period, it waits a hold gap and releases the select. After that it enforces a minimum deselect time, plus a longer gap when the next transfer addresses a different device. Every gap is counted in reference-clock cycles.

The configuration inputs (polarity, phase, divider, select code, decode mode and the 32-bit gap word) are copied into internal shadow registers. The copy happens only while `en_i` is low and no transfer is running. With `en_i` high the shadow copy is frozen, and a transfer may start. One-cycle `sample_o` and `shift_o` strobes mark the serial-clock edges on which the data path should capture and launch bits. There is no data stream at this block's edge, so the handshake is a plain level request with no back-pressure.

Top module: `spi_clk_cs_gen`

## Requirements
- R1: After reset `sclk_o` is 0, `cs_n_o` is 4'b1111, `idle_o` is 1, and `sample_o` and `shift_o` are 0.
- R2: Configuration inputs take effect only after `en_i` has been low for a clock edge while idle. Changing them while `en_i` is high has no effect on `sclk_o` or on the select pattern.
- R3: While running, `sclk_o` changes every div+1 reference cycles, where div is `div_i` (4 bits), giving a serial clock period of 2*(div+1). A transfer of n periods makes exactly 2n changes.
- R4: Whenever the block is idle with `en_i` high, `sclk_o` equals the polarity bit. A transfer always begins and ends at that level.
- R5: The first change of each period is the leading edge. With phase 0, `sample_o` pulses on leading edges and `shift_o` on trailing edges; with phase 1 the roles swap. The pulse is one cycle long, in the same cycle as the `sclk_o` change, and never appears otherwise.
- R6: With decode enabled, `cs_n_o` carries the 4-bit select code unchanged during a transfer.
- R7: With decode disabled, a code holding exactly one 0 bit (device k drives bit k low) is driven as-is. Any other code leaves `cs_n_o` at 4'b1111 while the clock still runs.
- R8: The select is low for gaps[7:0]+1 reference cycles before the first `sclk_o` change.
- R9: The request is sampled at each trailing edge. If it is low, `cs_n_o` rises gaps[15:8]+2*(div+1)+3 cycles after that edge, and never in a cycle in which `sclk_o` changes.
- R10: With the request waiting for the same device, the select stays high for exactly gaps[31:24]+2*(div+1)+1 cycles between transfers.
- R11: When the next select pattern differs from the last one, the high time is max(gaps[31:24]+2*(div+1), gaps[23:16])+1.
- R12: `idle_o` is 1 only with no transfer active and both gap timers expired. It rises max(gaps[31:24]+2*(div+1), gaps[23:16]) cycles after `cs_n_o` rises, and while it is 1 the select is 4'b1111.
- R13: While `en_i` is low no transfer starts: the request is ignored, the select stays 4'b1111 and `sclk_o` does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Controller enable; low allows the configuration to be copied |
| cpol_i | input | 1 | Serial-clock idle level |
| cpha_i | input | 1 | Capture-edge select |
| div_i | input | 4 | Clock divider, half period = div+1 |
| cs_code_i | input | 4 | Select code |
| decode_i | input | 1 | 1: code passes through, 0: one-hot active-low code |
| gaps_i | input | 32 | [7:0] setup, [15:8] hold, [23:16] device change, [31:24] min deselect |
| xfer_req_i | input | 1 | Level request from the sequencer to run the serial clock |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 4 | Active-low device selects |
| sample_o | output | 1 | Capture strobe |
| shift_o | output | 1 | Launch strobe |
| idle_o | output | 1 | No transfer and all gaps expired |

## Verification
The assertions assume that reset is asserted while the clock runs. They also assume that `en_i` and the configuration inputs are driven to known values at all times, since the strobe, select and idle relations are checked on every cycle after reset. The stimulus changes configuration only after waiting for `idle_o` and only while `en_i` is low. It drives every input one nanosecond after a rising edge. It drops the request only between edges, so the bench's own count of periods matches what the block samples at each trailing edge.

// File: rtl/spi_tmg_pkg.sv
package spi_tmg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2,
    ST_HOLD  = 2'd3
  } tmg_state_e;

  // slot index of each gap inside the gap word
  localparam int GAP_SETUP = 0;
  localparam int GAP_HOLD  = 1;
  localparam int GAP_D2D   = 2;
  localparam int GAP_DESEL = 3;
  localparam int GAP_SLOTS = 4;

  // built-in margins added on top of programmed counts
  localparam int HOLD_EXTRA  = 2;  // loaded value; output adds one more edge
  localparam int NUM_TIMERS  = 2;  // deselect and device-change timers
  localparam int TMR_DESEL   = 0;
  localparam int TMR_D2D     = 1;
endpackage

// File: rtl/spi_tmg_shadow.sv
module spi_tmg_shadow #(
  parameter int NCS   = 4,
  parameter int DIV_W = 4,
  parameter int DLY_W = 8,
  localparam int GW   = spi_tmg_pkg::GAP_SLOTS * DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             cpol_in,
  input  logic             cpha_in,
  input  logic [DIV_W-1:0] div_in,
  input  logic [NCS-1:0]   code_in,
  input  logic             dec_in,
  input  logic [GW-1:0]    gaps_in,
  output logic             cpol_q,
  output logic             cpha_q,
  output logic [DIV_W-1:0] div_q,
  output logic [NCS-1:0]   code_q,
  output logic             dec_q,
  output logic [GW-1:0]    gaps_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      div_q  <= '0;
      code_q <= '1;
      dec_q  <= 1'b0;
      gaps_q <= '0;
    end else if (load) begin
      cpol_q <= cpol_in;
      cpha_q <= cpha_in;
      div_q  <= div_in;
      code_q <= code_in;
      dec_q  <= dec_in;
      gaps_q <= gaps_in;
    end
  end
endmodule

// File: rtl/spi_tmg_cs_sel.sv
module spi_tmg_cs_sel #(
  parameter int NCS = 4,
  localparam int ZW = $clog2(NCS + 1)
) (
  input  logic [NCS-1:0] code,
  input  logic           dec,
  output logic [NCS-1:0] pattern
);
  logic [ZW-1:0] zeros;

  always_comb begin
    zeros = '0;
    for (int i = 0; i < NCS; i++) begin
      zeros = zeros + ZW'(~code[i]);
    end
    if (dec) begin
      pattern = code;
    end else if (zeros == ZW'(1)) begin
      pattern = code;
    end else begin
      pattern = '1;
    end
  end
endmodule

// File: rtl/spi_tmg_gap_ctr.sv
module spi_tmg_gap_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= val;
    end else if (cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/spi_clk_cs_gen.sv
module spi_clk_cs_gen #(
  parameter int NCS   = 4,
  parameter int DIV_W = 4,
  parameter int DLY_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic                 cpol_i,
  input  logic                 cpha_i,
  input  logic [DIV_W-1:0]     div_i,
  input  logic [NCS-1:0]       cs_code_i,
  input  logic                 decode_i,
  input  logic [4*DLY_W-1:0]   gaps_i,
  input  logic                 xfer_req_i,
  output logic                 sclk_o,
  output logic [NCS-1:0]       cs_n_o,
  output logic                 sample_o,
  output logic                 shift_o,
  output logic                 idle_o
);
  import spi_tmg_pkg::*;

  localparam int GW     = GAP_SLOTS * DLY_W;
  localparam int BASE_W = (DLY_W > DIV_W + 1) ? DLY_W : DIV_W + 1;
  localparam int CNT_W  = BASE_W + 2;

  logic             sh_cpol, sh_cpha, sh_dec;
  logic [DIV_W-1:0] sh_div;
  logic [NCS-1:0]   sh_code;
  logic [GW-1:0]    sh_gaps;

  tmg_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             sclk_q, lead_q, trail_q;
  logic [NCS-1:0]   cs_q, last_sel, pat;

  logic [CNT_W-1:0] half_m1, period, setup_ld, hold_ld;
  logic [CNT_W-1:0] tmr_val [NUM_TIMERS];
  logic             tmr_done [NUM_TIMERS];
  logic             load_shadow, start, same_dev, desel_now;

  assign load_shadow = !en_i && (state == ST_IDLE);

  spi_tmg_shadow #(.NCS(NCS), .DIV_W(DIV_W), .DLY_W(DLY_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_shadow),
    .cpol_in (cpol_i),
    .cpha_in (cpha_i),
    .div_in  (div_i),
    .code_in (cs_code_i),
    .dec_in  (decode_i),
    .gaps_in (gaps_i),
    .cpol_q  (sh_cpol),
    .cpha_q  (sh_cpha),
    .div_q   (sh_div),
    .code_q  (sh_code),
    .dec_q   (sh_dec),
    .gaps_q  (sh_gaps)
  );

  spi_tmg_cs_sel #(.NCS(NCS)) u_sel (
    .code    (sh_code),
    .dec     (sh_dec),
    .pattern (pat)
  );

  // derived counts from the frozen configuration
  assign half_m1  = CNT_W'(sh_div);
  assign period   = CNT_W'({sh_div, 1'b0}) + CNT_W'(2);
  assign setup_ld = CNT_W'(sh_gaps[GAP_SETUP*DLY_W +: DLY_W]);
  assign hold_ld  = CNT_W'(sh_gaps[GAP_HOLD*DLY_W +: DLY_W]) + period + CNT_W'(HOLD_EXTRA);
  assign tmr_val[TMR_DESEL] = CNT_W'(sh_gaps[GAP_DESEL*DLY_W +: DLY_W]) + period;
  assign tmr_val[TMR_D2D]   = CNT_W'(sh_gaps[GAP_D2D*DLY_W +: DLY_W]);

  assign desel_now = (state == ST_HOLD) && (cnt == '0);

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    spi_tmg_gap_ctr #(.W(CNT_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (desel_now),
      .val   (tmr_val[g]),
      .done  (tmr_done[g])
    );
  end

  assign same_dev = (pat == last_sel);
  assign start    = (state == ST_IDLE) && en_i && xfer_req_i &&
                    tmr_done[TMR_DESEL] && (same_dev || tmr_done[TMR_D2D]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sclk_q   <= 1'b0;
      cs_q     <= '1;
      last_sel <= '1;
      lead_q   <= 1'b0;
      trail_q  <= 1'b0;
    end else begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          sclk_q <= sh_cpol;
          if (start) begin
            cs_q     <= pat;
            last_sel <= pat;
            cnt      <= setup_ld;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            sclk_q <= ~sclk_q;
            lead_q <= 1'b1;
            cnt    <= half_m1;
            state  <= ST_RUN;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_RUN: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (sclk_q != sh_cpol) begin
            sclk_q  <= ~sclk_q;
            trail_q <= 1'b1;
            if (xfer_req_i) begin
              cnt <= half_m1;
            end else begin
              cnt   <= hold_ld;
              state <= ST_HOLD;
            end
          end else begin
            sclk_q <= ~sclk_q;
            lead_q <= 1'b1;
            cnt    <= half_m1;
          end
        end
        ST_HOLD: begin
          if (cnt == '0) begin
            cs_q  <= '1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o   = sclk_q;
  assign cs_n_o   = cs_q;
  assign sample_o = sh_cpha ? trail_q : lead_q;
  assign shift_o  = sh_cpha ? lead_q : trail_q;
  assign idle_o   = (state == ST_IDLE) && tmr_done[TMR_DESEL] && tmr_done[TMR_D2D];
endmodule

// File: rtl/spi_clk_cs_gen_chk.sv
module spi_clk_cs_gen_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en_i,
  input logic           sclk_o,
  input logic [NCS-1:0] cs_n_o,
  input logic           sample_o,
  input logic           shift_o,
  input logic           idle_o
);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_o && shift_o));

  // R5
  strobe_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o || shift_o) |-> (sclk_o != $past(sclk_o)));

  // R12
  idle_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (cs_n_o == '1));

  // R9
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&cs_n_o) |-> $stable(sclk_o));

  // R13
  en_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && idle_o) |=> (cs_n_o == '1));
endmodule

bind spi_clk_cs_gen spi_clk_cs_gen_chk #(.NCS(NCS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_i     (en_i),
  .sclk_o   (sclk_o),
  .cs_n_o   (cs_n_o),
  .sample_o (sample_o),
  .shift_o  (shift_o),
  .idle_o   (idle_o)
);

// File: tb/test_spi_clk_cs_gen.sv
`timescale 1ns/1ps
module test_spi_clk_cs_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0, cpol_i = 1'b0, cpha_i = 1'b0, decode_i = 1'b0;
  logic [3:0]  div_i = '0, cs_code_i = 4'hF;
  logic [31:0] gaps_i = '0;
  logic        xfer_req_i = 1'b0;
  logic        sclk_o, sample_o, shift_o, idle_o;
  logic [3:0]  cs_n_o;

  spi_clk_cs_gen i_spi_clk_cs_gen (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  // bench model of the applied configuration
  logic m_cpol = 1'b0, m_cpha = 1'b0, m_dec = 1'b0;
  logic [3:0] m_div = '0, m_code = 4'hF;
  logic [31:0] m_gaps = '0;

  // monitor state
  int cyc = 0, fall_cnt = 0, rise_cnt = 0, idle_cnt = 0, edge_total = 0;
  int t_fall, t_first, t_last, t_rise, t_idle, t_prev_edge;
  int n_edges = 0, n_trail = 0, bad_int = 0, bad_strobe = 0, bad_lvl = 0;
  bit in_x = 1'b0;
  logic [3:0] pat_seen;
  logic prev_sclk = 1'b0, prev_idle = 1'b1;
  logic [3:0] prev_cs = 4'hF;

  function automatic int half_p(); return int'(m_div) + 1; endfunction
  function automatic int gap_g(); return int'(m_gaps[31:24]) + 2 * half_p(); endfunction
  function automatic int gap_d(); return int'(m_gaps[23:16]); endfunction
  function automatic int maxi(int a, int b); return (a > b) ? a : b; endfunction
  function automatic logic [3:0] exp_pat(logic [3:0] code, logic dec);
    int z = 0;
    for (int i = 0; i < 4; i++) if (!code[i]) z++;
    if (dec || z == 1) return code;
    return 4'hF;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (sclk_o !== prev_sclk) begin
        logic lead, exp_s;
        edge_total++;
        lead  = (sclk_o != m_cpol);
        exp_s = m_cpha ? !lead : lead;
        if (sample_o !== exp_s || shift_o !== !exp_s) bad_strobe++;
        if (in_x) begin
          if (n_edges == 0) t_first = cyc;
          else if (cyc - t_prev_edge != half_p()) bad_int++;
          t_prev_edge = cyc;
          t_last = cyc;
          n_edges++;
          if (!lead) n_trail++;
        end
      end else if (sample_o || shift_o) begin
        bad_strobe++;
      end
      if (prev_cs == 4'hF && cs_n_o != 4'hF) begin
        in_x = 1'b1; t_fall = cyc; pat_seen = cs_n_o; fall_cnt++;
        n_edges = 0; n_trail = 0; bad_int = 0; bad_strobe = 0;
      end
      if (prev_cs != 4'hF && cs_n_o == 4'hF) begin
        in_x = 1'b0; t_rise = cyc; rise_cnt++;
      end
      if (!prev_idle && idle_o) begin
        t_idle = cyc; idle_cnt++;
      end
      if (idle_o && en_i && sclk_o !== m_cpol) bad_lvl++;
      prev_sclk = sclk_o; prev_cs = cs_n_o; prev_idle = idle_o;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic set_cfg(input logic pol, input logic pha, input logic [3:0] dv,
                         input logic [3:0] code, input logic dec, input logic [31:0] g);
    while (!idle_o) tick();
    en_i = 1'b0;
    cpol_i = pol; cpha_i = pha; div_i = dv; cs_code_i = code; decode_i = dec; gaps_i = g;
    tick(); tick();
    m_cpol = pol; m_cpha = pha; m_div = dv; m_code = code; m_dec = dec; m_gaps = g;
    en_i = 1'b1;
    tick();
  endtask

  task automatic one_xfer(input int n);
    int f0 = fall_cnt, r0 = rise_cnt;
    xfer_req_i = 1'b1;
    while (fall_cnt == f0) tick();
    while (n_trail < n - 1) tick();
    xfer_req_i = 1'b0;
    while (rise_cnt == r0) tick();
  endtask

  task automatic verify_xfer(input int n);
    logic [3:0] ep = exp_pat(m_code, m_dec);
    // R8 setup gap
    check(t_first - t_fall == int'(m_gaps[7:0]) + 1, "R8 setup", t_first - t_fall, int'(m_gaps[7:0]) + 1);
    // R3 edge count and half period
    check(n_edges == 2 * n && bad_int == 0, "R3 clock periods", n_edges * 100 + bad_int, 2 * n * 100);
    // R9 hold gap
    check(t_rise - t_last == int'(m_gaps[15:8]) + 2 * half_p() + 3, "R9 hold",
          t_rise - t_last, int'(m_gaps[15:8]) + 2 * half_p() + 3);
    // R5 strobes
    check(bad_strobe == 0, "R5 strobes", bad_strobe, 0);
    if (m_dec) check(pat_seen == ep, "R6 decode pattern", pat_seen, ep);
    else       check(pat_seen == ep, "R7 one-hot pattern", pat_seen, ep);
  endtask

  task automatic verify_idle(input int i0);
    while (idle_cnt == i0) tick();
    // R12 idle delay
    check(t_idle - t_rise == maxi(gap_g(), gap_d()), "R12 idle delay",
          t_idle - t_rise, maxi(gap_g(), gap_d()));
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed, i0, e0, f0, r0, pr;
    logic [3:0] code;
    seed = $urandom(20240611);
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #0.5;
    // R1 reset state
    check(sclk_o == 1'b0 && cs_n_o == 4'hF, "R1 reset outputs", {sclk_o, cs_n_o}, 5'h0F);
    check(idle_o == 1'b1 && !sample_o && !shift_o, "R1 reset flags", {idle_o, sample_o, shift_o}, 3'b100);
    tick();

    // R13: request ignored while disabled
    e0 = edge_total; f0 = fall_cnt;
    xfer_req_i = 1'b1;
    repeat (30) tick();
    xfer_req_i = 1'b0;
    check(edge_total == e0 && fall_cnt == f0 && idle_o, "R13 disabled", edge_total - e0 + fall_cnt - f0, 0);

    // directed minimum: all gaps zero, fastest clock, one period
    set_cfg(1'b0, 1'b0, 4'd0, 4'b1110, 1'b0, 32'h0);
    i0 = idle_cnt; one_xfer(1); verify_xfer(1); verify_idle(i0);

    // directed maximum gaps and slowest clock
    set_cfg(1'b1, 1'b1, 4'd15, 4'b0111, 1'b0, 32'hFFFF_FFFF);
    i0 = idle_cnt; one_xfer(2); verify_xfer(2); verify_idle(i0);

    // R10 / R11: same device versus device change, long device-change gap
    set_cfg(1'b0, 1'b1, 4'd0, 4'b1110, 1'b0, {8'd10, 8'd200, 8'd3, 8'd2});
    one_xfer(1);
    pr = t_rise; one_xfer(2);
    check(t_fall - pr == gap_g() + 1, "R10 same device", t_fall - pr, gap_g() + 1);
    verify_xfer(2);
    en_i = 1'b0; cs_code_i = 4'b1101;
    tick();
    en_i = 1'b1; m_code = 4'b1101;
    pr = t_rise; i0 = idle_cnt;
    one_xfer(1);
    check(t_fall - pr == maxi(gap_g(), gap_d()) + 1, "R11 device change",
          t_fall - pr, maxi(gap_g(), gap_d()) + 1);
    verify_xfer(1);

    // R2: inputs changed while enabled have no effect
    while (!idle_o) tick();
    cpol_i = 1'b1; cs_code_i = 4'b1011;
    repeat (6) tick();
    check(sclk_o == m_cpol, "R2 polarity frozen", sclk_o, m_cpol);
    one_xfer(1);
    check(pat_seen == 4'b1101, "R2 code frozen", pat_seen, 4'b1101);
    cpol_i = m_cpol; cs_code_i = m_code;

    // R7 invalid one-hot code: clock runs, selects stay high
    set_cfg(1'b0, 1'b0, 4'd2, 4'b1100, 1'b0, 32'h0101_0101);
    e0 = edge_total; f0 = fall_cnt; i0 = idle_cnt;
    xfer_req_i = 1'b1;
    while (edge_total == e0) tick();
    xfer_req_i = 1'b0;
    while (idle_cnt == i0) tick();
    check(fall_cnt == f0 && edge_total - e0 == 2, "R7 invalid code", (fall_cnt - f0) * 100 + edge_total - e0, 2);

    // constrained random transfers
    for (int it = 0; it < 14; it++) begin
      logic dec = 1'($urandom_range(0, 1));
      int n1 = $urandom_range(1, 4);
      logic [31:0] g;
      code = dec ? 4'($urandom_range(0, 14)) : (4'hF & ~(4'd1 << $urandom_range(0, 3)));
      g = {8'($urandom_range(0, 40)), 8'($urandom_range(0, 60)),
           8'($urandom_range(0, 40)), 8'($urandom_range(0, 40))};
      set_cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
              code, dec, g);
      i0 = idle_cnt;
      one_xfer(n1); verify_xfer(n1);
      if (it % 2 == 1) begin
        pr = t_rise;
        one_xfer(1);
        check(t_fall - pr == gap_g() + 1, "R10 back to back", t_fall - pr, gap_g() + 1);
        verify_xfer(1);
        i0 = idle_cnt;
      end
      verify_idle(i0);
    end

    // R4 idle level across the run
    check(bad_lvl == 0, "R4 idle level", bad_lvl, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule